// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the per-transfer datapath of a single DMA channel. Software loads three values: a 16-bit address register, an 8-bit page and a 16-bit count. The count is written as the number of transfers minus one. Each accepted transfer strobe registers the 24-bit physical byte address for that transfer, advances the address, and steps the count down. On the transfer that exhausts the count, the block raises a one-cycle terminal-count pulse. After that pulse it ignores further strobes until a new count is loaded.

A mode input selects byte or word operation. In byte mode the page forms the top eight address bits above the 16-bit address register. In word mode the address register is shifted up by one bit and bit 0 is held low, so the page contributes only its upper seven bits. The page is never incremented by the address: a run of transfers wraps inside its own 64 KiB (byte) or 128 KiB (word) window. The block also reports how much remains to be moved, in bytes. The page can be reloaded alone, between transfers, without touching the address or the count.

Top module: `dmaseq_channel`

## Requirements
- R1: After reset `phys_addr` is 0, `byte_en` is 0, `tc` is 0 and `residue` is 1, and transfer strobes are ignored (outputs unchanged, no `tc`) until a count is loaded.
- R2: Loading count value N makes exactly N+1 transfers accepted; `tc` is 1 for the last of them only (N=0 gives one transfer, N=0xFFFF gives 65536).
- R3: In byte mode (`word_mode`=0) an accepted transfer sets `phys_addr` to {page[7:0], addr[15:0]}; `byte_en` is 2'b01 when addr bit 0 is 0 and 2'b10 when it is 1.
- R4: In word mode (`word_mode`=1) an accepted transfer sets `phys_addr` to {page[7:1], addr[15:0], 1'b0}, so page bit 0 has no effect; `byte_en` is 2'b11.
- R5: Each accepted transfer increments the address register by one modulo 2^16; 0xFFFF wraps to 0x0000 and the page bits of `phys_addr` do not change.
- R6: `residue` equals ((count+1) mod 2^16) in byte mode and twice that in word mode, where count is the current count register. It is 0 once the last transfer has completed.
- R7: After terminal count, transfer strobes are ignored: `phys_addr`, `byte_en` and `residue` hold, and `tc` stays 0 until `ld_count` is pulsed.
- R8: `ld_page` alone replaces the page used by later transfers and leaves the current address and count registers unchanged.
- R9: When any load strobe is high in the same cycle as `xfer`, the load takes effect and the transfer is ignored.
- R10: `phys_addr`, `byte_en` and `tc` update on the clock edge that accepts the transfer. `tc` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 0 = byte channel, 1 = word channel |
| ld_addr | input | 1 | Load address register from `addr_in` |
| addr_in | input | 16 | Address register load value |
| ld_page | input | 1 | Load page from `page_in` |
| page_in | input | 8 | Page load value |
| ld_count | input | 1 | Load count register from `count_in` and re-arm |
| count_in | input | 16 | Number of transfers minus one |
| xfer | input | 1 | Transfer strobe |
| phys_addr | output | 24 | Physical byte address of the last accepted transfer |
| byte_en | output | 2 | Byte-lane hint for the last accepted transfer |
| tc | output | 1 | Terminal count pulse |
| residue | output | 17 | Bytes still to move |

## Verification
The bench starts a byte-mode run just below 0xFFFF. A design that carried into the page, or that checked the wrong lane from address bit 0, would show a different top byte or lane after the wrap. A word-mode run with an odd page tests whether page bit 0 leaks into A17, and it also tests the doubled residue at its 0x1FFFE maximum and its wrapped zero. The bench sends strobes after terminal count, together with load strobes, and after a page-only reload. A design that kept counting would move the address or pulse `tc` again. A design that let a load and a transfer coincide, or that disturbed the count on a page reload, would report a different next address or residue.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_WORD = 1'b1
  } xfer_mode_e;

  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_PAGE_W = 8;
  localparam int unsigned DEF_CNT_W  = 16;
endpackage

// File: rtl/dmaseq_count.sv
module dmaseq_count #(
  parameter int unsigned CNT_W = dmaseq_pkg::DEF_CNT_W,
  localparam int unsigned RES_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_mode,
  input  logic             ld_count,
  input  logic [CNT_W-1:0] count_in,
  input  logic             other_ld,
  input  logic             xfer,
  output logic             accept,
  output logic             tc,
  output logic [RES_W-1:0] residue
);
  import dmaseq_pkg::*;

  logic [CNT_W-1:0] count_q, count_d, plus1;
  logic             done_q;
  logic             last;
  xfer_mode_e       mode;

  assign mode   = xfer_mode_e'(word_mode);
  assign accept = xfer & ~done_q & ~ld_count & ~other_ld;
  assign last   = (count_q == '0);

  always_comb begin
    if (ld_count)    count_d = count_in;
    else if (accept) count_d = count_q - CNT_W'(1);
    else             count_d = count_q;
  end

  assign plus1 = count_d + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      done_q  <= 1'b1;
      tc      <= 1'b0;
      residue <= RES_W'(1);
    end else begin
      count_q <= count_d;
      if (ld_count)            done_q <= 1'b0;
      else if (accept && last) done_q <= 1'b1;
      tc      <= accept & last;
      residue <= (mode == MODE_WORD) ? {plus1, 1'b0} : {1'b0, plus1};
    end
  end

  // R2: each accepted transfer steps the count down by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> count_q == $past(count_q) - CNT_W'(1));

  // R6: residue reads zero in the terminal-count cycle
  p_res_zero_r6: assert property (@(posedge clk) disable iff (rst)
    tc |-> residue == '0);

  // R7: once done, nothing moves until a reload
  p_idle_done_r7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !ld_count) |=> ($stable(count_q) && !tc));

  // R10: terminal count is a single-cycle pulse
  p_tc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);
endmodule

// File: rtl/dmaseq_addr.sv
module dmaseq_addr #(
  parameter int unsigned ADDR_W = dmaseq_pkg::DEF_ADDR_W,
  parameter int unsigned PAGE_W = dmaseq_pkg::DEF_PAGE_W,
  localparam int unsigned PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_page,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              accept,
  output logic [PHYS_W-1:0] phys,
  output logic [1:0]        byte_en
);
  import dmaseq_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] page_q;
  logic [PHYS_W-1:0] map_byte, map_word;
  logic [1:0]        lane_byte;
  xfer_mode_e        mode;

  assign mode      = xfer_mode_e'(word_mode);
  assign map_byte  = {page_q, addr_q};
  assign map_word  = {page_q[PAGE_W-1:1], addr_q, 1'b0};
  assign lane_byte = addr_q[0] ? 2'b10 : 2'b01;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      page_q  <= '0;
      phys    <= '0;
      byte_en <= 2'b00;
    end else begin
      if (ld_addr)     addr_q <= addr_in;
      else if (accept) addr_q <= addr_q + ADDR_W'(1);
      if (ld_page)     page_q <= page_in;
      if (accept) begin
        phys    <= (mode == MODE_WORD) ? map_word : map_byte;
        byte_en <= (mode == MODE_WORD) ? 2'b11 : lane_byte;
      end
    end
  end

  // R4: word transfers are even-aligned and use both lanes
  p_word_align_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && word_mode) |=> (phys[0] == 1'b0 && byte_en == 2'b11));

  // R5: the address never carries into the page bits
  p_page_hold_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> phys[PHYS_W-1:PHYS_W-PAGE_W+1] == $past(page_q[PAGE_W-1:1]));

  // R8: a page-only reload leaves the address register alone
  p_page_only_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_page && !ld_addr) |=> $stable(addr_q));

  // R3: a byte transfer enables exactly one lane
  p_byte_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !word_mode) |=> $onehot0(byte_en) && byte_en != 2'b00);
endmodule

// File: rtl/dmaseq_channel.sv
module dmaseq_channel #(
  parameter int unsigned ADDR_W = dmaseq_pkg::DEF_ADDR_W,
  parameter int unsigned PAGE_W = dmaseq_pkg::DEF_PAGE_W,
  parameter int unsigned CNT_W  = dmaseq_pkg::DEF_CNT_W,
  localparam int unsigned PHYS_W = ADDR_W + PAGE_W,
  localparam int unsigned RES_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_page,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              ld_count,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              xfer,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [1:0]        byte_en,
  output logic              tc,
  output logic [RES_W-1:0]  residue
);
  logic accept;
  logic other_ld;

  assign other_ld = ld_addr | ld_page;

  dmaseq_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .word_mode(word_mode),
    .ld_count (ld_count),
    .count_in (count_in),
    .other_ld (other_ld),
    .xfer     (xfer),
    .accept   (accept),
    .tc       (tc),
    .residue  (residue)
  );

  dmaseq_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .word_mode(word_mode),
    .ld_addr  (ld_addr),
    .addr_in  (addr_in),
    .ld_page  (ld_page),
    .page_in  (page_in),
    .accept   (accept),
    .phys     (phys_addr),
    .byte_en  (byte_en)
  );

  // R9: a load in the same cycle blocks the transfer
  p_load_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer && (ld_addr || ld_page || ld_count)) |=> (!tc && $stable(phys_addr)));
endmodule

// File: tb/test_dmaseq_channel.sv
module test_dmaseq_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b0;
  logic        ld_addr = 1'b0, ld_page = 1'b0, ld_count = 1'b0, xfer = 1'b0;
  logic [15:0] addr_in = '0, count_in = '0;
  logic [7:0]  page_in = '0;
  logic [23:0] phys_addr;
  logic [1:0]  byte_en;
  logic        tc;
  logic [16:0] residue;

  always #10 clk = ~clk;

  dmaseq_channel i_dmaseq_channel (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .ld_addr(ld_addr), .addr_in(addr_in),
    .ld_page(ld_page), .page_in(page_in),
    .ld_count(ld_count), .count_in(count_in),
    .xfer(xfer), .phys_addr(phys_addr), .byte_en(byte_en),
    .tc(tc), .residue(residue)
  );

  typedef struct packed {
    logic [23:0] phys;
    logic [1:0]  be;
    logic        tcx;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    n_run = 0, n_fail = 0;
  bit    finished = 0;

  logic [15:0] m_addr = '0, m_cnt = '0;
  logic [7:0]  m_page = '0;
  logic        m_done = 1'b1;
  logic [23:0] m_phys = '0;
  logic [1:0]  m_be = '0;
  logic        x_seen = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [16:0] res_m();
    logic [15:0] p1;
    p1 = m_cnt + 16'd1;
    return word_mode ? {p1, 1'b0} : {1'b0, p1};
  endfunction

  task automatic pulse(input bit la, input logic [15:0] a,
                       input bit lp, input logic [7:0] p,
                       input bit lc, input logic [15:0] c,
                       input bit x, input string req);
    exp_t e;
    @(negedge clk);
    ld_addr = la; addr_in = a; ld_page = lp; page_in = p;
    ld_count = lc; count_in = c; xfer = x;
    if (x) begin
      e.tcx = 1'b0;
      if (!(la || lp || lc || m_done)) begin
        m_phys = word_mode ? {m_page[7:1], m_addr, 1'b0} : {m_page, m_addr};
        m_be   = word_mode ? 2'b11 : (m_addr[0] ? 2'b10 : 2'b01);
        e.tcx  = (m_cnt == 16'd0);
        if (e.tcx) m_done = 1'b1;
        m_addr = m_addr + 16'd1;
        m_cnt  = m_cnt - 16'd1;
      end
      e.phys = m_phys;
      e.be   = m_be;
      exp_q.push_back(e);
      req_q.push_back(req);
    end
    if (la) m_addr = a;
    if (lp) m_page = p;
    if (lc) begin m_cnt = c; m_done = 1'b0; end
    @(negedge clk);
    ld_addr = 0; ld_page = 0; ld_count = 0; xfer = 0;
  endtask

  task automatic do_x(input string req);
    pulse(0, 16'h0, 0, 8'h0, 0, 16'h0, 1, req);
  endtask

  task automatic chk_res(input string req);
    chk(req, "residue", 32'(residue), 32'(res_m()));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // scoreboard monitor
  always @(posedge clk) x_seen <= xfer;
  always @(negedge clk) begin
    if (x_seen && exp_q.size() > 0) begin
      exp_t  e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, "phys_addr", 32'(phys_addr), 32'(e.phys));
      chk(r, "byte_en", 32'(byte_en), 32'(e.be));
      chk(r, "tc", 32'(tc), 32'(e.tcx));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "phys_addr", 32'(phys_addr), 32'h0);
    chk("R1", "byte_en", 32'(byte_en), 32'h0);
    chk("R1", "tc", 32'(tc), 32'h0);
    chk("R1", "residue", 32'(residue), 32'h1);
    do_x("R1");
    chk_res("R1");

    // byte run across address wrap: R2 R3 R5 R6
    pulse(1, 16'hFFFE, 0, 8'h0, 0, 16'h0, 0, "R3");
    pulse(0, 16'h0, 1, 8'h12, 0, 16'h0, 0, "R3");
    pulse(0, 16'h0, 0, 8'h0, 1, 16'd2, 0, "R2");
    chk_res("R6");
    do_x("R3"); chk_res("R6");
    do_x("R3"); chk_res("R6");
    do_x("R5"); chk_res("R6");
    chk("R5", "phys_addr", 32'(phys_addr), 32'h120000);
    chk("R2", "residue done", 32'(residue), 32'h0);
    @(negedge clk);
    chk("R10", "tc after pulse", 32'(tc), 32'h0);
    // R7: ignored after terminal count
    do_x("R7");
    chk_res("R7");

    // word mode: R4 R6
    @(negedge clk); word_mode = 1'b1;
    pulse(1, 16'hFFFF, 0, 8'h0, 0, 16'h0, 0, "R4");
    pulse(0, 16'h0, 1, 8'h35, 0, 16'h0, 0, "R4");
    pulse(0, 16'h0, 0, 8'h0, 1, 16'd1, 0, "R4");
    chk_res("R6");
    do_x("R4"); chk_res("R6");
    chk("R4", "phys_addr", 32'(phys_addr), 32'h35FFFE);
    do_x("R4"); chk_res("R6");
    chk("R4", "phys_addr wrap", 32'(phys_addr), 32'h340000);
    pulse(0, 16'h0, 0, 8'h0, 1, 16'hFFFE, 0, "R6");
    chk("R6", "residue max word", 32'(residue), 32'h1FFFE);
    pulse(0, 16'h0, 0, 8'h0, 1, 16'hFFFF, 0, "R6");
    chk("R6", "residue full wrap", 32'(residue), 32'h0);

    // page-only reload: R8
    @(negedge clk); word_mode = 1'b0;
    pulse(1, 16'h0100, 0, 8'h0, 0, 16'h0, 0, "R8");
    pulse(0, 16'h0, 1, 8'h01, 0, 16'h0, 0, "R8");
    pulse(0, 16'h0, 0, 8'h0, 1, 16'd3, 0, "R8");
    do_x("R8");
    pulse(0, 16'h0, 1, 8'h7F, 0, 16'h0, 0, "R8");
    chk_res("R8");
    do_x("R8");
    chk("R8", "phys_addr", 32'(phys_addr), 32'h7F0101);

    // load with transfer in same cycle: R9
    pulse(0, 16'h0, 0, 8'h0, 1, 16'd5, 1, "R9");
    chk_res("R9");
    pulse(1, 16'h4000, 0, 8'h0, 0, 16'h0, 1, "R9");
    chk_res("R9");
    do_x("R9");
    chk("R9", "phys_addr", 32'(phys_addr), 32'h7F4000);
    chk_res("R9");

    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule